// File: doc/BRIEF.md
# Double-Buffered Frame Fetch Address Generator

This block sequences the word reads that move pixel data from video memory into the pixel buffer of a display pipeline. Each frame is stored as a run of consecutive 32-bit words starting at one of two base addresses. The block issues a read request whenever the downstream buffer has room. It advances the word address on every acknowledged read and tracks how many pixels those words carry at the selected colour depth.

When the running pixel count reaches the frame size (visible width times visible height), the block flips to the other bank. It reloads the address from that bank's base and pulses a frame-done flag for one cycle. Software can then refill the idle bank while the other one is being scanned. Dropping the enable input pauses fetching. When enable returns, the current frame restarts from its bank's base.

Top module: `frame_fetch_agen`

## Requirements
- R1: While reset is asserted and in the first cycle after reset is released, `req_o` and `frame_done_o` are 0 and `bank_o` is 0. The first address presented with a request is `base0_i`.
- R2: `req_o` is 0 whenever `buf_full_i` is 1. With `en_i` high, no reload pending and `buf_full_i` low, `req_o` is 1 whether or not `ack_i` is high.
- R3: A read is accepted in a cycle where `req_o` and `ack_i` are both 1. After an accepted read that does not end the frame, `addr_o` is one greater. Without an accepted read, `addr_o` holds its value.
- R4: Pixels credited per accepted word depend on `depth_i`: code 00 (8 bpp) credits 4, code 01 (16 bpp) credits 2, and code 11 (32 bpp) credits 1. The frame ends on the first word that brings the count to width*height or beyond.
- R5: Code 10 (24 bpp) credits 1, 1, then 2 pixels over each group of three words, restarting the pattern at each frame start.
- R6: In the cycle after the frame-ending read, `frame_done_o` is 1 for exactly one cycle, `req_o` is 0 and `bank_o` has toggled. In the following cycle, `addr_o` equals the base of the new bank (bank 0 uses `base0_i`, bank 1 uses `base1_i`).
- R7: Width and height are sampled when a frame starts. Changing them during a frame does not alter that frame's length.
- R8: While `en_i` is 0, `req_o` is 0 and `bank_o` does not change. After `en_i` returns to 1, fetching restarts at the current bank's base with the pixel count cleared, so a full frame of words follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Fetch enable |
| base0_i | input | AW | Word base address of bank 0 |
| base1_i | input | AW | Word base address of bank 1 |
| width_i | input | DIMW | Visible pixels per line |
| height_i | input | DIMW | Visible lines per frame |
| depth_i | input | 2 | Colour depth code (00=8, 01=16, 10=24, 11=32 bpp) |
| buf_full_i | input | 1 | Downstream pixel buffer full |
| ack_i | input | 1 | Memory accepts the current request |
| req_o | output | 1 | Read request |
| addr_o | output | AW | Word address of the request |
| bank_o | output | 1 | Bank currently being fetched |
| frame_done_o | output | 1 | One-cycle pulse after the last read of a frame |

## Verification
A wrong pixel credit or a corrupt 24 bpp phase moves the frame boundary. This shows up at the ports as `frame_done_o` arriving too early or too late, measured in accepted words. A stuck or skipped address appears on the very next accepted read as a gap in the consecutive sequence. A bank register that fails to flip appears one cycle after the pulse, as a reload from the wrong base. A reload that does not take effect after disable appears at the first request after re-enable.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [1:0] {
    DEPTH_8  = 2'b00,
    DEPTH_16 = 2'b01,
    DEPTH_24 = 2'b10,
    DEPTH_32 = 2'b11
  } depth_e;

  localparam int unsigned STEP_W = 3;
endpackage

// File: rtl/fetch_pix_step.sv
module fetch_pix_step
  import fetch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  depth_e            depth_i,
  output logic [STEP_W-1:0] step_o
);
  logic [1:0] phase_q;

  // 24 bpp: three-word group credits 1,1,2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          phase_q <= 2'd0;
    else if (clr_i)                       phase_q <= 2'd0;
    else if (adv_i && depth_i == DEPTH_24) phase_q <= (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
  end

  always_comb begin
    unique case (depth_i)
      DEPTH_8:  step_o = STEP_W'(4);
      DEPTH_16: step_o = STEP_W'(2);
      DEPTH_24: step_o = (phase_q == 2'd2) ? STEP_W'(2) : STEP_W'(1);
      default:  step_o = STEP_W'(1);
    endcase
  end

  assert_phase_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3);

  assert_phase_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_q == 2'd0);
endmodule

// File: rtl/fetch_frame_cnt.sv
module fetch_frame_cnt
  import fetch_pkg::*;
#(
  parameter int unsigned DIMW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [DIMW-1:0]   width_i,
  input  logic [DIMW-1:0]   height_i,
  output logic              last_o
);
  localparam int unsigned PIXW = 2 * DIMW;

  logic [PIXW-1:0] total_q, cnt_q;
  logic [PIXW:0]   sum;

  assign sum    = {1'b0, cnt_q} + (PIXW+1)'(step_i);
  assign last_o = adv_i && (sum >= {1'b0, total_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      total_q <= PIXW'(width_i) * PIXW'(height_i);
      cnt_q   <= '0;
    end else if (adv_i) begin
      cnt_q   <= last_o ? '0 : sum[PIXW-1:0];
    end
  end

  assert_cnt_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> cnt_q == '0);

  assert_total_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(total_q));
endmodule

// File: rtl/frame_fetch_agen.sv
module frame_fetch_agen
  import fetch_pkg::*;
#(
  parameter int unsigned AW   = 24,
  parameter int unsigned DIMW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [AW-1:0]   base0_i,
  input  logic [AW-1:0]   base1_i,
  input  logic [DIMW-1:0] width_i,
  input  logic [DIMW-1:0] height_i,
  input  logic [1:0]      depth_i,
  input  logic            buf_full_i,
  input  logic            ack_i,
  output logic            req_o,
  output logic [AW-1:0]   addr_o,
  output logic            bank_o,
  output logic            frame_done_o
);
  logic              reload_q, bank_q, done_q, acc, last, clr;
  logic [AW-1:0]     addr_q;
  logic [STEP_W-1:0] step;
  logic [AW-1:0]     base_sel;

  assign req_o = en_i && !reload_q && !buf_full_i;
  assign acc   = req_o && ack_i;
  assign clr   = reload_q || !en_i;

  generate
    if (AW > 0) begin : g_base_mux
      assign base_sel = bank_q ? base1_i : base0_i;
    end
  endgenerate

  fetch_pix_step u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (acc),
    .depth_i(depth_e'(depth_i)),
    .step_o (step)
  );

  fetch_frame_cnt #(.DIMW(DIMW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (clr),
    .adv_i   (acc),
    .step_i  (step),
    .width_i (width_i),
    .height_i(height_i),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= 1'b1;
      bank_q   <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
    end else begin
      reload_q <= !en_i || last;
      done_q   <= last;
      if (last) bank_q <= !bank_q;
      if (reload_q)  addr_q <= base_sel;
      else if (acc)  addr_q <= addr_q + AW'(1);
    end
  end

  assign addr_o       = addr_q;
  assign bank_o       = bank_q;
  assign frame_done_o = done_q;

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !last) |=> addr_o == AW'($past(addr_o) + 1'b1));

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc && !reload_q) |=> $stable(addr_o));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  assert_done_no_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !req_o);

  assert_bank_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_o != $past(bank_o)) |-> frame_done_o);

  assert_reload_base_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> addr_o == (bank_o ? $past(base1_i) : $past(base0_i)));

  assert_disable_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_o);
endmodule

// File: tb/frame_fetch_agen_bench.sv
module frame_fetch_agen_bench;
  localparam int unsigned AW   = 24;
  localparam int unsigned DIMW = 12;
  localparam logic [AW-1:0] B0 = 24'h000100;
  localparam logic [AW-1:0] B1 = 24'h000800;

  typedef struct packed {
    logic [1:0]  dep;
    logic [11:0] w;
    logic [11:0] h;
    logic [15:0] words;
  } vec_t;

  // expected words: ceil(px/4), ceil(px/2), 24bpp 1,1,2 groups, px
  localparam vec_t VECS [7] = '{
    '{2'd0, 12'd8, 12'd2, 16'd4},
    '{2'd1, 12'd6, 12'd3, 16'd9},
    '{2'd2, 12'd8, 12'd3, 16'd18},
    '{2'd3, 12'd5, 12'd2, 16'd10},
    '{2'd2, 12'd5, 12'd1, 16'd4},
    '{2'd0, 12'd5, 12'd2, 16'd3},
    '{2'd1, 12'd3, 12'd1, 16'd2}
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b1;
  logic [1:0]      depth_i = 2'd0;
  logic [DIMW-1:0] width_i = '0, height_i = '0;
  logic            buf_full_i = 1'b0, ack_i = 1'b1;
  logic            req_o, bank_o, frame_done_o;
  logic [AW-1:0]   addr_o;

  int errs = 0, checks = 0;
  logic exp_bank = 1'b0;

  always #10 clk = ~clk;

  frame_fetch_agen #(.AW(AW), .DIMW(DIMW)) u_frame_fetch_agen (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i),
    .base0_i(B0), .base1_i(B1),
    .width_i(width_i), .height_i(height_i), .depth_i(depth_i),
    .buf_full_i(buf_full_i), .ack_i(ack_i),
    .req_o(req_o), .addr_o(addr_o), .bank_o(bank_o), .frame_done_o(frame_done_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [1:0] dep, input logic [11:0] w, input logic [11:0] h,
                           input int exp_words, input int chg_at, input int dis_at,
                           input int stall_at, input string tag);
    int n = 0;
    bit done_seen = 1'b0, dis_done = 1'b0, stall_done = 1'b0, chg_done = 1'b0;
    logic [AW-1:0] base = exp_bank ? B1 : B0;
    logic [AW-1:0] held;
    depth_i = dep; width_i = w; height_i = h;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      step_cyc();
      if (frame_done_o) begin done_seen = 1'b1; break; end
      if (dis_at > 0 && n == dis_at && !dis_done) begin
        dis_done = 1'b1;
        en_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
          step_cyc();
          chk(req_o == 1'b0, "R8 req while disabled", req_o, 0);
        end
        chk(bank_o == exp_bank, "R8 bank held", bank_o, exp_bank);
        en_i = 1'b1;
        n = 0;
      end
      if (stall_at > 0 && n == stall_at && !stall_done) begin
        stall_done = 1'b1;
        held = addr_o;
        buf_full_i = 1'b1;
        for (int k = 0; k < 2; k++) begin
          step_cyc();
          chk(req_o == 1'b0, "R2 req with full", req_o, 0);
          chk(addr_o == held, "R3 addr hold full", addr_o, held);
        end
        buf_full_i = 1'b0;
        ack_i = 1'b0;
        for (int k = 0; k < 2; k++) begin
          step_cyc();
          chk(req_o == 1'b1, "R2 req without ack", req_o, 1);
          chk(addr_o == held, "R3 addr hold no ack", addr_o, held);
        end
        ack_i = 1'b1;
      end
      if (chg_at > 0 && n == chg_at && !chg_done) begin
        chg_done = 1'b1;
        width_i = 12'd100;
      end
      if (req_o && ack_i) begin
        chk(addr_o == AW'(base + AW'(n)), (n == 0) ? "R6 base reload" : "R3 addr sequence",
            addr_o, AW'(base + AW'(n)));
        n++;
      end
    end
    chk(done_seen, "R6 frame done seen", done_seen, 1);
    chk(n == exp_words, tag, n, exp_words);
    chk(req_o == 1'b0, "R6 req low at done", req_o, 0);
    exp_bank = !exp_bank;
    chk(bank_o == exp_bank, "R6 bank toggle", bank_o, exp_bank);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    depth_i = VECS[0].dep; width_i = VECS[0].w; height_i = VECS[0].h;
    repeat (3) @(negedge clk);
    chk(req_o == 1'b0, "R1 req in reset", req_o, 0);
    chk(bank_o == 1'b0, "R1 bank in reset", bank_o, 0);
    chk(frame_done_o == 1'b0, "R1 done in reset", frame_done_o, 0);
    rst_ni = 1'b1;
    chk(req_o == 1'b0, "R1 req after release", req_o, 0);

    // vector table: word count per frame by depth; first entry checks R1 base0
    for (int i = 0; i < 7; i++)
      run_frame(VECS[i].dep, VECS[i].w, VECS[i].h, VECS[i].words, 0, 0, 0,
                (VECS[i].dep == 2'd2) ? "R5 words 24bpp" : "R4 words per frame");

    // R7: width change mid-frame
    run_frame(2'd3, 12'd4, 12'd2, 8, 2, 0, 0, "R7 sampled size");
    // R8: disable mid-frame, restart from bank base
    run_frame(2'd0, 12'd8, 12'd4, 8, 0, 3, 0, "R8 restart words");
    // R2/R3: buffer full and ack low stalls
    run_frame(2'd1, 12'd4, 12'd2, 4, 0, 0, 2, "R2 stall words");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule